// File: doc/BRIEF.md
# Serial Device Interrupt Request Gate

This block produces the single interrupt request of a serial-port-style device. The device has a receive side and a transmit side. Both sides share one status register address and one request line toward the CPU. A one-cycle receive event latches a "byte waiting" flag. That flag stays set until software reads the data register. A level input saying the transmitter can take a byte is registered and shown as a second flag.

Each source has its own enable bit in a control register. The CPU side supplies a global enable input. The request line is asserted whenever a flag is set, its own enable is set and the global enable is high. Software then reads the status register to find out which side needs service.

A receive condition that arrives while interrupts are masked is not lost. The latched flag keeps it pending, and the request appears as soon as the enables allow it. The request is a level. It stays high until software removes the cause or masks it, so no acknowledge sequencing exists in the block. The block has no streaming interface: the register port, the event pin and the request pin are plain control signals. A register access completes in the cycle it is presented, and the block never applies back-pressure.

Top module: `dev_irq_gate`

## Requirements
- R1: After reset the byte-waiting flag is 0, both enable bits are 0 and `irq_req` is 0.
- R2: A cycle with `rx_event` high sets the byte-waiting flag (status bit 0) at that clock edge.
- R3: A read of the data register (address 0) clears the byte-waiting flag at that clock edge. If `rx_event` is high in the same cycle, the flag stays set.
- R4: Status bit 1 shows the value `tx_space` had at the most recent clock edge.
- R5: A write to the control register (address 2) loads the receive enable from bit 0 and the transmit enable from bit 1. Reading address 2 returns these two bits, and every other bit reads as 0.
- R6: `irq_req` equals `cpu_ie & ((rxflag & rx_en) | (txflag & tx_en))`. It is combinational from the registered flags and the enables.
- R7: A byte-waiting flag set while interrupts are masked stays pending. `irq_req` rises in the same cycle `cpu_ie` rises, or right after the control write that enables the receive source.
- R8: `irq_req` falls no later than the clock edge that clears the causing flag, or the edge that writes its enable to 0.
- R9: Writes to the data (0) or status (1) addresses change neither the enable bits nor the flags.
- R10: Reading the status register leaves the byte-waiting flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_event | input | 1 | One-cycle pulse: a received byte is available |
| rx_byte | input | DATA_W | Received byte, returned when the data address is read |
| tx_space | input | 1 | Level: transmitter can accept a byte |
| cpu_ie | input | 1 | Global interrupt enable from the CPU side |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq_req | output | 1 | Interrupt request level |

## Verification
The bench builds the block with the default DATA_W of 8. It sweeps all 32 combinations of global enable, the two source enables, the receive flag and the transmit level. For each combination it compares the request line and the status word against the gating formula. The small width also lets the bench check the undefined control bits by writing all ones and expecting exactly 0x03 back. Directed sequences then cover the timing cases:
- a receive flag held pending while masked and released by the global enable or by the enable write;
- an event colliding with a data read;
- writes aimed at the wrong addresses;
- a request dropping when its cause is cleared or masked.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int ADDR_W = 2;
  localparam int NSRC   = 2;
  localparam int SRC_RX = 0;
  localparam int SRC_TX = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/irqg_flags.sv
module irqg_flags
  import irqg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_event,
  input  logic            rx_taken,
  input  logic            tx_space,
  output logic [NSRC-1:0] flags
);
  logic rx_flag_q;
  logic tx_flag_q;

  // a new event wins over a simultaneous read of the data register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_flag_q <= 1'b0;
    else if (rx_event) rx_flag_q <= 1'b1;
    else if (rx_taken) rx_flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_flag_q <= 1'b0;
    else        tx_flag_q <= tx_space;
  end

  assign flags[SRC_RX] = rx_flag_q;
  assign flags[SRC_TX] = tx_flag_q;

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_event |=> flags[SRC_RX]); // R2
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rx_taken && !rx_event) |=> !flags[SRC_RX]); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flags[SRC_RX] && !rx_taken) |=> flags[SRC_RX]); // R7
  AST_TX_TRACK: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (flags[SRC_TX] == $past(tx_space))); // R4
endmodule

// File: rtl/irqg_ctrl.sv
module irqg_ctrl
  import irqg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   enables
);
  logic [NSRC-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_ctrl) en_q <= wdata[NSRC-1:0];
  end

  assign enables = en_q;

  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_ctrl |=> $stable(enables)); // R9
endmodule

// File: rtl/irqg_gate.sv
module irqg_gate
  import irqg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enables,
  input  logic            global_en,
  output logic            req
);
  logic [NSRC-1:0] term;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign term[g] = flags[g] & enables[g];
  end

  assign req = global_en & (|term);

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n) req |-> global_en); // R6
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) req |-> ((flags & enables) != '0)); // R8
endmodule

// File: rtl/dev_irq_gate.sv
module dev_irq_gate
  import irqg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_event,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_space,
  input  logic              cpu_ie,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);
  localparam int PAD_W = DATA_W - NSRC;

  logic            rd_data;
  logic            wr_ctrl;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] enables;

  assign rd_data = bus_sel & ~bus_wr & (bus_addr == REG_DATA);
  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == REG_CTRL);

  irqg_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_event (rx_event),
    .rx_taken (rd_data),
    .tx_space (tx_space),
    .flags    (flags)
  );

  irqg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata),
    .enables (enables)
  );

  irqg_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .enables   (enables),
    .global_en (cpu_ie),
    .req       (irq_req)
  );

  always_comb begin
    unique case (bus_addr)
      REG_DATA: bus_rdata = rx_byte;
      REG_STAT: bus_rdata = {{PAD_W{1'b0}}, flags};
      REG_CTRL: bus_rdata = {{PAD_W{1'b0}}, enables};
      default:  bus_rdata = '0;
    endcase
  end

  AST_STATUS_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == REG_STAT && !rx_event && flags[SRC_RX]) |=> flags[SRC_RX]); // R10
  AST_CTRL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (enables == $past(bus_wdata[NSRC-1:0]))); // R5
endmodule

// File: tb/dev_irq_gate_tb.sv
module dev_irq_gate_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_event = 1'b0;
  logic [DW-1:0] rx_byte = 8'hA5;
  logic          tx_space = 1'b0;
  logic          cpu_ie = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dev_irq_gate #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_event(rx_event), .rx_byte(rx_byte),
    .tx_space(tx_space), .cpu_ie(cpu_ie), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse_rx();
    rx_event = 1;
    @(negedge clk);
    rx_event = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [DW-1:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    peek(2'd1, v); check("R1", int'(v[0]), 0);
    peek(2'd2, v); check("R1", int'(v), 0);
    check("R1", int'(irq_req), 0);

    // R5: control write and readback, undefined bits read 0
    wr(2'd2, 8'hFF); peek(2'd2, v); check("R5", int'(v), 8'h03);
    wr(2'd2, 8'h00); peek(2'd2, v); check("R5", int'(v), 0);

    // R6 sweep: gie, rx_en, tx_en, rx flag, tx level
    for (int c = 0; c < 32; c++) begin
      logic g, re, te, rf, tl;
      {g, re, te, rf, tl} = 5'(c);
      cpu_ie = 0;
      wr(2'd2, {6'd0, te, re});
      tx_space = tl;
      if (rf) pulse_rx(); else rd(2'd0, v);
      @(negedge clk);
      cpu_ie = g;
      peek(2'd1, v);
      check("R6 status", int'(v), int'({6'd0, tl, rf}));
      check("R6 irq", int'(irq_req), int'(g & ((rf & re) | (tl & te))));
    end

    // R2/R4: event sets flag, tx level tracked
    cpu_ie = 0; tx_space = 0; rd(2'd0, v); wr(2'd2, 8'h00);
    @(negedge clk);
    pulse_rx(); peek(2'd1, v); check("R2", int'(v[0]), 1);
    tx_space = 1; @(negedge clk); peek(2'd1, v); check("R4", int'(v[1]), 1);
    tx_space = 0; @(negedge clk); peek(2'd1, v); check("R4", int'(v[1]), 0);

    // R10: status read does not clear
    rd(2'd1, v); peek(2'd1, v); check("R10", int'(v[0]), 1);

    // R7: pending while masked, released by global enable, then by enable write
    check("R7 masked", int'(irq_req), 0);
    wr(2'd2, 8'h01); check("R7 gie off", int'(irq_req), 0);
    cpu_ie = 1; #1 check("R7 gie rise", int'(irq_req), 1);
    wr(2'd2, 8'h00); check("R8 mask", int'(irq_req), 0);
    wr(2'd2, 8'h01); check("R7 enable write", int'(irq_req), 1);

    // R3/R8: data read clears flag and request
    rd(2'd0, v); check("R3 data", int'(v), 8'hA5);
    peek(2'd1, v); check("R3", int'(v[0]), 0);
    check("R8 clear", int'(irq_req), 0);

    // R3: event and data read in the same cycle -> flag stays set
    rx_event = 1; rd(2'd0, v); rx_event = 0;
    peek(2'd1, v); check("R3 collide", int'(v[0]), 1);
    check("R6 collide", int'(irq_req), 1);

    // R9: writes to data/status addresses have no effect
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    peek(2'd2, v); check("R9 ctrl", int'(v), 1);
    peek(2'd1, v); check("R9 flag", int'(v[0]), 1);
    check("R9 irq", int'(irq_req), 1);

    // R8: transmit source drops when its level drops
    rd(2'd0, v); wr(2'd2, 8'h02); tx_space = 1; @(negedge clk);
    check("R8 tx on", int'(irq_req), 1);
    tx_space = 0; @(negedge clk);
    check("R8 tx off", int'(irq_req), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule